// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight level-sensitive interrupt request lines into a request register. It resolves one winner among the lines that are unmasked and not blocked by an in-service line of equal or higher priority. When a winner exists it raises a single interrupt line to the processor. The processor answers with three acknowledge strobes, each active low. During those strobes the block drives a complete call instruction onto an 8-bit data bus: first the call opcode, then the low byte and then the high byte of a per-line service-routine address.

Software programs the block through a small synchronous write port. It can set the mask, load the 16-bit vector base and choose fixed or rotating priority. It also issues end-of-interrupt commands, which retire the highest-priority in-service line. In-service bits take part in arbitration, so a more urgent line can interrupt a routine that is still running. This gives nested service without help from the processor.

Top module: `vpic_top`

## Requirements
- R1: The request register samples `irq_in` on every clock edge. `int_out` goes high one cycle after an unmasked line rises, provided nothing is in service.
- R2: Under fixed priority, line 0 is the most urgent and line 7 the least. With lines 2, 4 and 6 requesting, line 2 is the one served.
- R3: A write to address 0 loads the mask, where bit i set removes line i from arbitration. With lines 2 and 3 masked and lines 2, 3 and 4 requesting, line 4 is served. With every line masked, `int_out` stays low.
- R4: `int_out` is high only if an unmasked requesting line is strictly more urgent than every in-service line. With line 5 in service, a request on line 4 raises it, while a request on line 6 or line 5 does not.
- R5: An acknowledge sequence is three low pulses on `ack_n`. While `ack_n` is low, `data_oe` is 1 and `data_out` carries, in turn, 0xCD, the vector's bits 7:0 and the vector's bits 15:8. While `ack_n` is high, `data_oe` is 0.
- R6: The vector is the base plus four times the line number, modulo 2^16. A write to address 1 replaces all 16 bits of the base.
- R7: The line is chosen, and its in-service bit set, on the first acknowledge pulse. Request changes after that pulse do not alter the second and third bytes.
- R8: `int_out` is low from the first acknowledge pulse until the third pulse ends.
- R9: A write to address 3 (end of interrupt) clears the most urgent set in-service bit under the current priority order. The data written with it is ignored.
- R10: A write to address 2 with bit 0 set selects rotating priority, and bit 0 clear selects fixed priority. Under rotating priority, the line cleared by an end-of-interrupt becomes the least urgent and the next line becomes the most urgent. Until the first such command, the order equals fixed priority.
- R11: After reset the mask is clear, the base is 0, priority is fixed, nothing is in service, and `int_out` and `data_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 8 | Level-sensitive request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mask, 1 base, 2 mode, 3 end of interrupt |
| wr_data | input | 16 | Write data |
| int_out | output | 1 | Interrupt request to the processor |
| ack_n | input | 1 | Acknowledge strobe, active low |
| data_out | output | 8 | Instruction byte driven during acknowledge |
| data_oe | output | 1 | High while `data_out` is valid |

## Verification
The nesting boundary is probed with a request on the in-service line itself and with one just below it. A resolver that compared with "greater or equal" would re-interrupt itself or let a lower line through. A late, more urgent request is injected between the first and second pulses. A controller that re-resolved per pulse would emit a vector whose bytes belong to two different lines. The base is set so the sum wraps, which catches a truncated or misaligned adder. The test then serves two nested lines and retires them in turn, and checks under rotating priority that the retired line drops to the bottom of the order. Either an end-of-interrupt that cleared the wrong bit or a pointer that did not move shows up as the wrong line being served.

// File: rtl/vpic_pkg.sv
// Shared constants and types for the vectored priority interrupt controller.
// Assumes an 8-bit instruction bus and a 16-bit service address.
package vpic_pkg;
    localparam int BYTE_W = 8;
    localparam int VEC_W  = 2 * BYTE_W;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_MASK = 2'd0;
    localparam logic [ADDR_W-1:0] REG_BASE = 2'd1;
    localparam logic [ADDR_W-1:0] REG_MODE = 2'd2;
    localparam logic [ADDR_W-1:0] REG_EOI  = 2'd3;

    localparam logic [BYTE_W-1:0] CALL_OPCODE = 8'hCD;

    typedef enum logic [1:0] {
        PH_OPCODE = 2'd0,
        PH_VEC_LO = 2'd1,
        PH_VEC_HI = 2'd2
    } ack_phase_t;
endpackage

// File: rtl/vpic_regs.sv
// Software-visible configuration: mask, vector base and priority mode.
// Decodes an end-of-interrupt command into a one-cycle pulse.
// Assumes N_IRQ <= DATA_W; writes take effect on the clock edge.
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int DATA_W = VEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N_IRQ-1:0]  mask,
    output logic [DATA_W-1:0] base,
    output logic              rot_mode,
    output logic              eoi_pulse
);
    // Register updates from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask     <= '0;
            base     <= '0;
            rot_mode <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_MASK: mask     <= wr_data[N_IRQ-1:0];
                REG_BASE: base     <= wr_data;
                REG_MODE: rot_mode <= wr_data[0];
                default:  ;
            endcase
        end
    end

    // End-of-interrupt command strobe.
    always_comb eoi_pulse = wr_en && (wr_addr == REG_EOI);
endmodule

// File: rtl/vpic_resolver.sv
// Combinational priority resolver. Lines are ordered starting just after
// low_ptr (most urgent) and ending at low_ptr (least urgent).
// Reports the most urgent candidate request and the most urgent in-service
// line, and whether the request outranks all in-service lines.
// Assumes N_IRQ is a power of two so index arithmetic wraps.
module vpic_resolver #(
    parameter int N_IRQ = 8,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] irr,
    input  logic [N_IRQ-1:0] mask,
    input  logic [N_IRQ-1:0] isr,
    input  logic [IDX_W-1:0] low_ptr,
    output logic             raise,
    output logic [IDX_W-1:0] req_line,
    output logic             svc_valid,
    output logic [IDX_W-1:0] svc_line
);
    logic [N_IRQ-1:0] cand;
    logic [N_IRQ-1:0] cand_rot;
    logic [N_IRQ-1:0] isr_rot;
    logic             req_found;
    logic [IDX_W-1:0] req_rank;
    logic [IDX_W-1:0] svc_rank;

    // Candidates are active and unmasked.
    always_comb cand = irr & ~mask;

    // Rotate both vectors so rank 0 is the most urgent line.
    for (genvar k = 0; k < N_IRQ; k++) begin : g_rot
        assign cand_rot[k] = cand[low_ptr + IDX_W'(k + 1)];
        assign isr_rot[k]  = isr[low_ptr + IDX_W'(k + 1)];
    end

    // Lowest set rank in a vector.
    function automatic logic [IDX_W:0] first_set(input logic [N_IRQ-1:0] v);
        logic [IDX_W:0] r;
        r = '0;
        for (int k = N_IRQ - 1; k >= 0; k--) begin
            if (v[k]) r = {1'b1, IDX_W'(k)};
        end
        return r;
    endfunction

    // Pick winners and compare ranks for nesting.
    always_comb begin
        {req_found, req_rank} = first_set(cand_rot);
        {svc_valid, svc_rank} = first_set(isr_rot);
        raise    = req_found && (!svc_valid || (req_rank < svc_rank));
        req_line = low_ptr + req_rank + IDX_W'(1);
        svc_line = low_ptr + svc_rank + IDX_W'(1);
    end
endmodule

// File: rtl/vpic_ack_seq.sv
// Acknowledge sequencer. Samples ack_n, counts three low pulses and drives
// opcode, vector low byte and vector high byte while ack_n is low.
// The line is frozen on the falling edge of the first pulse.
// Assumes ack_n is synchronous to clk and each level lasts at least one cycle.
module vpic_ack_seq
    import vpic_pkg::*;
#(
    parameter int N_IRQ = 8,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_n,
    input  logic              req_ok,
    input  logic [IDX_W-1:0]  req_line,
    input  logic [VEC_W-1:0]  base,
    output logic              grant,
    output logic              busy,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe
);
    logic             ack_q;
    ack_phase_t       phase;
    logic [IDX_W-1:0] line_q;
    logic             fall;
    logic             rise;
    logic [VEC_W-1:0] vector;

    // Edge detection on the strobe.
    always_comb begin
        fall = ack_q && !ack_n;
        rise = !ack_q && ack_n;
    end

    // Strobe history, pulse counter and frozen line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b1;
            phase  <= PH_OPCODE;
            line_q <= '0;
        end else begin
            ack_q <= ack_n;
            if (fall && phase == PH_OPCODE) line_q <= req_line;
            if (rise) begin
                case (phase)
                    PH_OPCODE: phase <= PH_VEC_LO;
                    PH_VEC_LO: phase <= PH_VEC_HI;
                    default:   phase <= PH_OPCODE;
                endcase
            end
        end
    end

    // Grant on the first falling edge and busy flag for the interrupt line.
    always_comb begin
        grant = fall && (phase == PH_OPCODE) && req_ok;
        busy  = (phase != PH_OPCODE) || !ack_q;
    end

    // Vector address of the frozen line.
    always_comb vector = base + {{(VEC_W - IDX_W - 2){1'b0}}, line_q, 2'b00};

    // Byte mux onto the bus while the strobe is low.
    always_comb begin
        data_oe  = !ack_n;
        data_out = '0;
        if (!ack_n) begin
            case (phase)
                PH_OPCODE: data_out = CALL_OPCODE;
                PH_VEC_LO: data_out = vector[BYTE_W-1:0];
                default:   data_out = vector[VEC_W-1:BYTE_W];
            endcase
        end
    end
endmodule

// File: rtl/vpic_top.sv
// Vectored priority interrupt controller top. Holds request and in-service
// registers and the rotation pointer, and ties resolver, configuration and
// acknowledge sequencer together.
// Assumes level-sensitive requests synchronous to clk.
module vpic_top
    import vpic_pkg::*;
#(
    parameter int N_IRQ = 8,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VEC_W-1:0]  wr_data,
    output logic              int_out,
    input  logic              ack_n,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe
);
    logic [N_IRQ-1:0] irr_q;
    logic [N_IRQ-1:0] isr_q;
    logic [N_IRQ-1:0] mask;
    logic [VEC_W-1:0] base;
    logic             rot_mode;
    logic             eoi_pulse;
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] eff_ptr;
    logic             raise;
    logic [IDX_W-1:0] req_line;
    logic             svc_valid;
    logic [IDX_W-1:0] svc_line;
    logic             grant;
    logic             busy;
    logic [N_IRQ-1:0] set_mask;
    logic [N_IRQ-1:0] clr_mask;
    logic             eoi_hit;

    vpic_regs #(.N_IRQ(N_IRQ), .DATA_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mask(mask), .base(base), .rot_mode(rot_mode),
        .eoi_pulse(eoi_pulse)
    );

    vpic_resolver #(.N_IRQ(N_IRQ)) u_res (
        .irr(irr_q), .mask(mask), .isr(isr_q), .low_ptr(eff_ptr),
        .raise(raise), .req_line(req_line), .svc_valid(svc_valid),
        .svc_line(svc_line)
    );

    vpic_ack_seq #(.N_IRQ(N_IRQ)) u_ack (
        .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .req_ok(raise),
        .req_line(req_line), .base(base), .grant(grant), .busy(busy),
        .data_out(data_out), .data_oe(data_oe)
    );

    // Fixed priority uses the top line as the permanent lowest.
    always_comb eff_ptr = rot_mode ? ptr_q : IDX_W'(N_IRQ - 1);

    // Bits to set on grant and clear on end of interrupt.
    always_comb begin
        eoi_hit  = eoi_pulse && svc_valid;
        set_mask = grant   ? (N_IRQ'(1) << req_line) : '0;
        clr_mask = eoi_hit ? (N_IRQ'(1) << svc_line) : '0;
    end

    // Request sampling, in-service tracking and rotation pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            ptr_q <= IDX_W'(N_IRQ - 1);
        end else begin
            irr_q <= irq_in;
            isr_q <= (isr_q & ~clr_mask) | set_mask;
            if (eoi_hit && rot_mode) ptr_q <= svc_line;
        end
    end

    // Interrupt output, held low during an acknowledge sequence.
    always_comb int_out = raise && !busy;
endmodule

// File: rtl/vpic_top_chk.sv
// Property checker for vpic_top, attached by bind.
module vpic_top_chk #(
    parameter int N_IRQ = 8,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_out,
    input logic             ack_n,
    input logic [N_IRQ-1:0] irr,
    input logic [N_IRQ-1:0] mask,
    input logic [N_IRQ-1:0] isr,
    input logic             grant,
    input logic [IDX_W-1:0] req_line,
    input logic             eoi
);
    // R3
    int_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (|(irr & ~mask)));

    // R7
    grant_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> isr[$past(req_line)]);

    // R7
    one_new_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr & ~$past(isr)) <= 1);

    // R9
    eoi_clears_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && (|isr) && !grant) |=> ($countones(isr) == $past($countones(isr)) - 1));

    // R8
    quiet_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && $past(!ack_n)) |-> !int_out);
endmodule

bind vpic_top vpic_top_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .int_out(int_out), .ack_n(ack_n),
    .irr(irr_q), .mask(mask), .isr(isr_q), .grant(grant),
    .req_line(req_line), .eoi(eoi_pulse)
);

// File: tb/vpic_top_test.sv
// Directed bench for vpic_top: one task per scenario.
module vpic_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  irq_in;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic        int_out;
    logic        ack_n;
    logic [7:0]  data_out;
    logic        data_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    vpic_top uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .int_out(int_out),
        .ack_n(ack_n), .data_out(data_out), .data_oe(data_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_in = '0; wr_en = 1'b0; wr_addr = '0;
        wr_data = '0; ack_n = 1'b1;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    // Three acknowledge pulses; optionally change requests after the first.
    task automatic ack3(input bit inject, input logic [7:0] new_irq,
                        output logic [7:0] b0, output logic [7:0] b1,
                        output logic [7:0] b2);
        logic [7:0] bytes [3];
        for (int p = 0; p < 3; p++) begin
            ack_n = 1'b0;
            tick(1);
            bytes[p] = data_out;
            check("R5", "oe while strobe low", 32'(data_oe), 32'd1);
            check("R8", "int low during acknowledge", 32'(int_out), 32'd0);
            ack_n = 1'b1;
            if (p == 0 && inject) irq_in = new_irq;
            tick(1);
            check("R5", "oe while strobe high", 32'(data_oe), 32'd0);
        end
        b0 = bytes[0]; b1 = bytes[1]; b2 = bytes[2];
    endtask

    task automatic t_reset();
        logic [7:0] b0, b1, b2;
        do_reset();
        check("R11", "int after reset", 32'(int_out), 32'd0);
        check("R11", "oe after reset", 32'(data_oe), 32'd0);
        irq_in = 8'hFF;
        tick(1);
        check("R1", "int one cycle after request", 32'(int_out), 32'd1);
        ack3(0, '0, b0, b1, b2);
        check("R5", "opcode byte", 32'(b0), 32'hCD);
        check("R11", "zero base low byte, line 0", 32'(b1), 32'h00);
        check("R11", "zero base high byte", 32'(b2), 32'h00);
    endtask

    task automatic t_fixed();
        logic [7:0] b0, b1, b2;
        do_reset();
        irq_in = 8'b0101_0100;
        tick(1);
        check("R1", "int raised", 32'(int_out), 32'd1);
        ack3(0, '0, b0, b1, b2);
        check("R2", "line 2 wins low byte", 32'(b1), 32'h08);
        check("R2", "line 2 wins high byte", 32'(b2), 32'h00);
    endtask

    task automatic t_mask();
        logic [7:0] b0, b1, b2;
        do_reset();
        wr(2'd0, 16'h00FF);
        irq_in = 8'hFF;
        tick(2);
        check("R3", "all masked keeps int low", 32'(int_out), 32'd0);
        wr(2'd0, 16'h000C);
        irq_in = 8'h1C;
        tick(1);
        check("R3", "int with line 4 unmasked", 32'(int_out), 32'd1);
        ack3(0, '0, b0, b1, b2);
        check("R3", "line 4 served", 32'(b1), 32'h10);
    endtask

    task automatic t_vector();
        logic [7:0] b0, b1, b2;
        do_reset();
        wr(2'd1, 16'hFFF8);
        irq_in = 8'h08;
        tick(1);
        ack3(0, '0, b0, b1, b2);
        check("R6", "wrapped vector low", 32'(b1), 32'h04);
        check("R6", "wrapped vector high", 32'(b2), 32'h00);
        wr(2'd1, 16'h12A0);
        wr(2'd3, 16'hBEEF);
        tick(1);
        check("R9", "int back after end of interrupt", 32'(int_out), 32'd1);
        ack3(0, '0, b0, b1, b2);
        check("R6", "new base low", 32'(b1), 32'hAC);
        check("R6", "new base high", 32'(b2), 32'h12);
    endtask

    task automatic t_nest_eoi();
        logic [7:0] b0, b1, b2;
        do_reset();
        irq_in = 8'h20;
        tick(1);
        ack3(0, '0, b0, b1, b2);
        check("R4", "line 5 served", 32'(b1), 32'h14);
        tick(1);
        check("R4", "same line in service blocks", 32'(int_out), 32'd0);
        irq_in = 8'h60;
        tick(2);
        check("R4", "lower line blocked", 32'(int_out), 32'd0);
        irq_in = 8'h30;
        tick(2);
        check("R4", "higher line nests", 32'(int_out), 32'd1);
        ack3(0, '0, b0, b1, b2);
        check("R4", "line 4 served nested", 32'(b1), 32'h10);
        irq_in = 8'h40;
        tick(2);
        check("R9", "line 6 blocked by 4 and 5", 32'(int_out), 32'd0);
        wr(2'd3, 16'h0000);
        tick(1);
        check("R9", "line 6 still blocked by 5", 32'(int_out), 32'd0);
        wr(2'd3, 16'h0000);
        tick(1);
        check("R9", "line 6 free after second eoi", 32'(int_out), 32'd1);
    endtask

    task automatic t_freeze();
        logic [7:0] b0, b1, b2;
        do_reset();
        irq_in = 8'h80;
        tick(1);
        ack3(1, 8'h81, b0, b1, b2);
        check("R7", "frozen line 7 low", 32'(b1), 32'h1C);
        check("R7", "frozen line 7 high", 32'(b2), 32'h00);
        check("R8", "int returns for line 0", 32'(int_out), 32'd1);
    endtask

    task automatic t_rotate();
        logic [7:0] b0, b1, b2;
        do_reset();
        wr(2'd2, 16'h0001);
        irq_in = 8'h24;
        tick(1);
        ack3(0, '0, b0, b1, b2);
        check("R10", "rotating starts as fixed", 32'(b1), 32'h08);
        do_reset();
        wr(2'd2, 16'h0001);
        irq_in = 8'h08;
        tick(1);
        ack3(0, '0, b0, b1, b2);
        check("R10", "line 3 served", 32'(b1), 32'h0C);
        irq_in = 8'h00;
        wr(2'd3, 16'h0000);
        irq_in = 8'h24;
        tick(2);
        check("R10", "int after rotation", 32'(int_out), 32'd1);
        ack3(0, '0, b0, b1, b2);
        check("R10", "line 5 outranks line 2", 32'(b1), 32'h14);
    endtask

    initial begin
        t_reset();
        t_fixed();
        t_mask();
        t_vector();
        t_nest_eoi();
        t_freeze();
        t_rotate();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule